// File: doc/BRIEF.md
# Sixteen-Entry Multi-Mode Key Match Store

The block keeps a small table of 8-bit keys, each with its own valid flag, and finds which stored keys equal a presented search key. One compare datapath checks all entries against the key in parallel, and the caller picks one of two result views for each search. The priority view gives the lowest matching slot and a hit flag. The vector view gives a mask of every matching slot.

Slots are loaded by index. Slots are removed either one at a time or all together in a single cycle. A search always sees the table as it stood before the clock edge that registers its result. A load or clear issued in the same cycle therefore affects only later searches. The result is registered and appears one cycle after the search request.

Top module: `kmc_top`

## Requirements
- R1: After reset every slot is invalid and all response outputs are zero; a search issued right after reset reports no hit and an all-zero vector.
- R2: With `load_en` high, `load_key` is stored into slot `load_slot`, and that slot becomes valid at the next clock edge.
- R3: With `find_en` high and `find_all` low (priority view), the next cycle shows `rsp_valid`=1, `rsp_hit`=1 and `rsp_slot` = the lowest-numbered valid slot whose key equals `find_key`, and `rsp_mask`=0.
- R4: With `find_en` high and `find_all` high (vector view), the next cycle shows `rsp_valid`=1, bit i of `rsp_mask` set exactly when slot i is valid and holds `find_key`, `rsp_hit` = OR of the mask, and `rsp_slot`=0.
- R5: An invalid slot never matches, whatever key value it still holds.
- R6: With `drop_en` high and `drop_every` low, only slot `drop_slot` becomes invalid; every other slot keeps its key and its valid flag.
- R7: With `drop_en` high and `drop_every` high, every slot is invalid after a single clock edge.
- R8: A search issued in the same cycle as a load sees the slot contents as they were before that load.
- R9: A drop and a load in the same cycle that target the same slot leave that slot invalid, and a drop of every slot overrides any load in that cycle.
- R10: In a cycle that follows one with `find_en` low, `rsp_valid`, `rsp_hit`, `rsp_slot` and `rsp_mask` are all zero.
- R11: A priority-view search with no matching valid slot gives `rsp_valid`=1, `rsp_hit`=0 and `rsp_slot`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_en | input | 1 | Store a key into a slot |
| load_slot | input | 4 | Slot index for the load |
| load_key | input | 8 | Key value to store |
| drop_en | input | 1 | Invalidate slot(s) |
| drop_every | input | 1 | 1: invalidate all slots; 0: only `drop_slot` |
| drop_slot | input | 4 | Slot index for a single drop |
| find_en | input | 1 | Issue a search this cycle |
| find_all | input | 1 | 1: vector view; 0: priority view |
| find_key | input | 8 | Key to search for |
| rsp_valid | output | 1 | Registered: a search result is present |
| rsp_hit | output | 1 | Registered: at least one valid slot matched |
| rsp_slot | output | 4 | Registered: lowest matching slot (priority view) |
| rsp_mask | output | 16 | Registered: per-slot match mask (vector view) |

## Verification
Some properties are checked on every cycle. These cover the one-cycle response latency and the all-zero quiet outputs, and they check that the vector never flags a slot that was invalid. They also check that a reported priority slot is a real match with no lower match, and that both kinds of drop take effect at the next edge. Other behaviours need specific stimulus in the bench's scenarios. These are the before-load view of a search in the same cycle as a load, the priority between a drop and a load on one slot, the survival of untouched slots after a single drop, and the exact key-to-slot results. A reference table in the bench, advanced on every clock, covers these.

// File: rtl/kmc_pkg.sv
package kmc_pkg;

    typedef enum logic {
        VIEW_PRIORITY = 1'b0,
        VIEW_VECTOR   = 1'b1
    } view_e;

endpackage

// File: rtl/kmc_store.sv
module kmc_store #(
    parameter int SLOTS = 16,
    parameter int KEY_W = 8,
    localparam int IDX_W = $clog2(SLOTS)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         load_en,
    input  logic [IDX_W-1:0]             load_slot,
    input  logic [KEY_W-1:0]             load_key,
    input  logic                         drop_en,
    input  logic                         drop_every,
    input  logic [IDX_W-1:0]             drop_slot,
    output logic [SLOTS-1:0][KEY_W-1:0]  keys,
    output logic [SLOTS-1:0]             live
);

    typedef struct packed {
        logic [SLOTS-1:0][KEY_W-1:0] key;
        logic [SLOTS-1:0]            vld;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < SLOTS; i++) begin
            if (load_en && load_slot == IDX_W'(i)) begin
                st_d.key[i] = load_key;
                st_d.vld[i] = 1'b1;
            end
            // a drop wins over a load on the same slot
            if (drop_en && (drop_every || drop_slot == IDX_W'(i))) begin
                st_d.vld[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign keys = st_q.key;
    assign live = st_q.vld;

    a_r7_drop_every_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_en && drop_every) |=> (live == '0));

    a_r6_drop_one_clears_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_en && !drop_every) |=> (((live >> $past(drop_slot)) & SLOTS'(1)) == '0));

    a_r2_load_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && !drop_en) |=> (((live >> $past(load_slot)) & SLOTS'(1)) != '0));

endmodule

// File: rtl/kmc_match.sv
module kmc_match #(
    parameter int SLOTS = 16,
    parameter int KEY_W = 8
) (
    input  logic [SLOTS-1:0][KEY_W-1:0] keys,
    input  logic [SLOTS-1:0]            live,
    input  logic [KEY_W-1:0]            probe,
    output logic [SLOTS-1:0]            hits
);

    for (genvar g = 0; g < SLOTS; g++) begin : g_cmp
        assign hits[g] = live[g] && (keys[g] == probe);
    end

endmodule

// File: rtl/kmc_prienc.sv
module kmc_prienc #(
    parameter int SLOTS = 16,
    localparam int IDX_W = $clog2(SLOTS)
) (
    input  logic [SLOTS-1:0] req,
    output logic             any,
    output logic [IDX_W-1:0] first
);

    always_comb begin
        first = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (req[i]) begin
                first = IDX_W'(i);
            end
        end
    end

    assign any = |req;

endmodule

// File: rtl/kmc_top.sv
module kmc_top #(
    parameter int SLOTS = 16,
    parameter int KEY_W = 8,
    localparam int IDX_W = $clog2(SLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [IDX_W-1:0] load_slot,
    input  logic [KEY_W-1:0] load_key,
    input  logic             drop_en,
    input  logic             drop_every,
    input  logic [IDX_W-1:0] drop_slot,
    input  logic             find_en,
    input  logic             find_all,
    input  logic [KEY_W-1:0] find_key,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic [IDX_W-1:0] rsp_slot,
    output logic [SLOTS-1:0] rsp_mask
);

    import kmc_pkg::*;

    typedef struct packed {
        logic             valid;
        logic             hit;
        logic [IDX_W-1:0] slot;
        logic [SLOTS-1:0] mask;
    } rsp_t;

    logic [SLOTS-1:0][KEY_W-1:0] keys;
    logic [SLOTS-1:0]            live;
    logic [SLOTS-1:0]            hits;
    logic                        any_hit;
    logic [IDX_W-1:0]            first_hit;
    view_e                       view;
    rsp_t                        rsp_d, rsp_q;

    kmc_store #(.SLOTS(SLOTS), .KEY_W(KEY_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_en    (load_en),
        .load_slot  (load_slot),
        .load_key   (load_key),
        .drop_en    (drop_en),
        .drop_every (drop_every),
        .drop_slot  (drop_slot),
        .keys       (keys),
        .live       (live)
    );

    kmc_match #(.SLOTS(SLOTS), .KEY_W(KEY_W)) u_match (
        .keys  (keys),
        .live  (live),
        .probe (find_key),
        .hits  (hits)
    );

    kmc_prienc #(.SLOTS(SLOTS)) u_prienc (
        .req   (hits),
        .any   (any_hit),
        .first (first_hit)
    );

    assign view = find_all ? VIEW_VECTOR : VIEW_PRIORITY;

    always_comb begin
        rsp_d = '0;
        if (find_en) begin
            rsp_d.valid = 1'b1;
            rsp_d.hit   = any_hit;
            if (view == VIEW_VECTOR) begin
                rsp_d.mask = hits;
            end else begin
                rsp_d.slot = first_hit;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_hit   = rsp_q.hit;
    assign rsp_slot  = rsp_q.slot;
    assign rsp_mask  = rsp_q.mask;

    a_r3_one_cycle_latency: assert property (@(posedge clk) disable iff (!rst_n)
        find_en |=> rsp_valid);

    a_r10_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !find_en |=> (!rsp_valid && !rsp_hit && rsp_slot == '0 && rsp_mask == '0));

    a_r5_mask_only_live: assert property (@(posedge clk) disable iff (!rst_n)
        find_en |=> ((rsp_mask & ~$past(live)) == '0));

    a_r3_slot_is_lowest: assert property (@(posedge clk) disable iff (!rst_n)
        (find_en && !find_all && any_hit) |=>
            ((((live >> rsp_slot) & SLOTS'(1)) != '0 || $past(drop_en)) &&
             rsp_hit &&
             (($past(hits) & ((SLOTS'(1) << rsp_slot) - SLOTS'(1))) == '0)));

    a_r11_miss_zero_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (find_en && !any_hit) |=> (!rsp_hit && rsp_slot == '0 && rsp_mask == '0));

endmodule

// File: tb/kmc_top_bench.sv
module kmc_top_bench;

    localparam int SLOTS = 16;
    localparam int KEY_W = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load_en = 0, drop_en = 0, drop_every = 0, find_en = 0, find_all = 0;
    logic [3:0] load_slot = 0, drop_slot = 0;
    logic [7:0] load_key = 0, find_key = 0;
    logic       rsp_valid, rsp_hit;
    logic [3:0] rsp_slot;
    logic [15:0] rsp_mask;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;

    // reference table
    int  ref_key [SLOTS];
    bit  ref_vld [SLOTS];

    always #5 clk = ~clk;

    kmc_top u_kmc_top (
        .clk(clk), .rst_n(rst_n),
        .load_en(load_en), .load_slot(load_slot), .load_key(load_key),
        .drop_en(drop_en), .drop_every(drop_every), .drop_slot(drop_slot),
        .find_en(find_en), .find_all(find_all), .find_key(find_key),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_slot(rsp_slot), .rsp_mask(rsp_mask)
    );

    task automatic idle_inputs();
        load_en = 0; drop_en = 0; drop_every = 0; find_en = 0; find_all = 0;
    endtask

    task automatic compare(string req, bit ev, bit eh, int es, int em);
        vectors++;
        if (rsp_valid !== ev || rsp_hit !== eh || int'(rsp_slot) != es || int'(rsp_mask) != em) begin
            miscompares++;
            $display("FAIL %s: act valid=%0d hit=%0d slot=%0d mask=%h exp valid=%0d hit=%0d slot=%0d mask=%h",
                     req, rsp_valid, rsp_hit, rsp_slot, rsp_mask, ev, eh, es, em);
        end
    endtask

    // one clock: predict from current inputs, advance the model, compare after edge
    task automatic step(string req);
        bit ev = 0, eh = 0;
        int es = 0, em = 0, m = 0, lowest = -1;
        if (find_en) begin
            for (int i = 0; i < SLOTS; i++) begin
                if (ref_vld[i] && ref_key[i] == int'(find_key)) begin
                    m = m | (1 << i);
                    if (lowest < 0) lowest = i;
                end
            end
            ev = 1;
            eh = (m != 0);
            if (find_all) em = m;
            else es = (lowest < 0) ? 0 : lowest;
        end
        if (load_en) begin
            ref_key[load_slot] = int'(load_key);
            ref_vld[load_slot] = 1;
        end
        if (drop_en) begin
            for (int i = 0; i < SLOTS; i++)
                if (drop_every || int'(drop_slot) == i) ref_vld[i] = 0;
        end
        @(posedge clk);
        #1;
        compare(req, ev, eh, es, em);
        idle_inputs();
    endtask

    task automatic do_load(int s, int k, string req);
        load_en = 1; load_slot = 4'(s); load_key = 8'(k);
        step(req);
    endtask

    task automatic do_find(int k, bit all, string req);
        find_en = 1; find_all = all; find_key = 8'(k);
        step(req);
    endtask

    initial begin
        for (int i = 0; i < SLOTS; i++) begin ref_key[i] = 0; ref_vld[i] = 0; end
        repeat (3) @(posedge clk);
        #1;
        compare("R1", 0, 0, 0, 0);            // reset state at the ports
        rst_n = 1;
        do_find(0, 1, "R1");                  // empty table
        do_find(0, 0, "R1");

        do_load(3, 8'h5A, "R2");
        do_load(7, 8'h5A, "R2");
        do_load(9, 8'h11, "R2");
        do_load(15, 8'hFF, "R2");
        do_load(0, 8'h00, "R2");

        do_find(8'h5A, 0, "R3");              // expect slot 3
        do_find(8'h11, 0, "R3");              // slot 9
        do_find(8'hFF, 0, "R3");              // slot 15
        do_find(8'h42, 0, "R11");             // miss
        do_find(8'h5A, 1, "R4");              // mask bits 3 and 7
        do_find(8'h00, 1, "R5");              // only slot 0, others hold stale 0

        // search together with a load to slot 3
        load_en = 1; load_slot = 4'd3; load_key = 8'h77;
        find_en = 1; find_all = 0; find_key = 8'h5A;
        step("R8");                           // still sees slot 3 = 5A
        do_find(8'h5A, 0, "R8");              // now slot 7
        do_find(8'h77, 1, "R2");

        drop_en = 1; drop_every = 0; drop_slot = 4'd7;
        step("R6");
        do_find(8'h5A, 1, "R6");              // gone
        do_find(8'h11, 0, "R6");              // slot 9 survives
        do_find(8'h77, 1, "R6");

        // drop and load on the same slot
        drop_en = 1; drop_slot = 4'd9; load_en = 1; load_slot = 4'd9; load_key = 8'h11;
        step("R9");
        do_find(8'h11, 1, "R9");

        // drop everything while loading slot 2
        drop_en = 1; drop_every = 1; load_en = 1; load_slot = 4'd2; load_key = 8'h33;
        step("R7");
        do_find(8'hFF, 1, "R7");
        do_find(8'h33, 0, "R9");
        do_find(8'h00, 1, "R7");

        step("R10");                          // idle cycle
        step("R10");

        for (int n = 0; n < 400; n++) begin
            load_en = $urandom_range(0, 1);
            load_slot = 4'($urandom); load_key = 8'($urandom_range(0, 7));
            drop_en = ($urandom_range(0, 5) == 0);
            drop_every = ($urandom_range(0, 7) == 0);
            drop_slot = 4'($urandom);
            find_en = $urandom_range(0, 3) != 0;
            find_all = $urandom_range(0, 1);
            find_key = 8'($urandom_range(0, 7));
            step(find_all ? "R4" : "R3");
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #200000;
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: act running exp finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule